// File: doc/BRIEF.md
# Split-Datapath Operand Store

This block is the bus-facing storage for a wide modular multiplier. It holds four working operands and one modulus, each a stack of 32-bit words with the least significant word at index 0. Software moves data in and out one word at a time over a single port: a 9-bit address, a write strobe, a write word and a registered read word. The datapath side has its own port. It reads two operands, chosen by x and y selects, together with the modulus, all at one shared word index. It writes results into the operand named by the destination select.

The multiplier datapath can be split into a lower part and an upper part, and a 2-bit part select sets which bus word indices count as valid. Bus reads of operand space are steered by the destination select, so software reads back whichever operand the datapath last targeted. A registered collision flag marks any bus write that clashes with datapath traffic on the same operand. The clashing write is discarded so that the datapath's view stays consistent.

Top module: `operand_store`

## Requirements
- R1: Address bits 8:6 select the target and bits 5:0 give the word index. Selector values 0 to 3 name operands 0 to 3, and 4 names the modulus. A bus write with bus_we=1 stores bus_wdata at that word, provided R3, R4, R5 and R9 do not block it.
- R2: A bus read returns its word on bus_rdata one cycle after the address is presented. For selectors 0 to 3 the word comes from the operand named by dest_sel, not from the address selector. For selector 4 it comes from the modulus.
- R3: Selectors 5 to 7 map to nothing. Writes to them are ignored and reads from them return zero.
- R4: Word indices 48 to 63 are ignored for writes and read as zero.
- R5: part_sel sets the valid bus word window: 2'b11 allows words 0 to 47, 2'b01 allows words 0 to 15, 2'b10 allows words 16 to 47, and 2'b00 allows none. Writes outside the window are ignored and reads outside it return zero.
- R6: One cycle after dp_idx is presented, dp_x_data, dp_y_data and dp_mod_data carry that word of the operand named by dp_x_sel, of the operand named by dp_y_sel and of the modulus. part_sel has no effect on them, and indices above 47 give zero.
- R7: When dp_wr_en=1, dp_wdata is stored at word dp_idx of the operand named by dest_sel (indices above 47 are ignored).
- R8: collision goes high for exactly the cycle after a bus write clashes with the datapath. A clash is a write to operand k while dp_rd_en=1 and k equals dp_x_sel or dp_y_sel, or a write to operand k while dp_wr_en=1 and k equals dest_sel, or a write to the modulus while dp_rd_en=1.
- R9: A clashing bus write is dropped and leaves storage unchanged. A datapath write in the same cycle still takes effect.
- R10: After reset all stored words are zero and every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 9 | Selector (8:6) and word index (5:0) |
| bus_we | input | 1 | Bus write strobe |
| bus_wdata | input | 32 | Bus write word |
| bus_rdata | output | 32 | Registered bus read word |
| part_sel | input | 2 | Datapath part window select |
| dest_sel | input | 2 | Destination operand, also steers bus read-back |
| dp_idx | input | 6 | Datapath word index |
| dp_rd_en | input | 1 | Datapath is reading x, y and modulus |
| dp_x_sel | input | 2 | Operand on the x read port |
| dp_y_sel | input | 2 | Operand on the y read port |
| dp_wr_en | input | 1 | Datapath write strobe |
| dp_wdata | input | 32 | Datapath write word |
| dp_x_data | output | 32 | Registered x operand word |
| dp_y_data | output | 32 | Registered y operand word |
| dp_mod_data | output | 32 | Registered modulus word |
| collision | output | 1 | Registered clash flag |

## Verification
The assertions check on every cycle the properties that need no storage model. Unmapped selectors, out-of-range indices and out-of-window lower-part reads must return zero a cycle later. The collision flag must rise after a modulus clash and must never rise without a bus write. Datapath reads past word 47 must give zero. What was actually stored can only be shown by the bench's scenarios, which compare every output against a shadow copy of the five operands. Those scenarios cover read-back steering by dest_sel, dropped clashing writes, window filtering of writes and datapath writes becoming visible on the bus.

// File: rtl/opmem_pkg.sv
package opmem_pkg;
    localparam int SEL_W   = 3;   // target selector field width
    localparam int IDX_W   = 6;   // word index field width
    localparam int OP_W    = 2;   // operand id width
    localparam int NUM_OPS = 4;   // working operands; the next selector is the modulus

    typedef enum logic [1:0] {
        PART_NONE = 2'b00,
        PART_LOW  = 2'b01,
        PART_HIGH = 2'b10,
        PART_FULL = 2'b11
    } part_e;

    typedef struct packed {
        logic            is_op;
        logic            is_mod;
        logic [OP_W-1:0] op_id;
        logic [IDX_W-1:0] idx;
        logic            in_win;
    } bus_dec_t;
endpackage

// File: rtl/opmem_decode.sv
module opmem_decode
    import opmem_pkg::*;
#(
    parameter int NUM_WORDS = 48,
    parameter int LOW_WORDS = 16
) (
    input  logic [SEL_W+IDX_W-1:0] addr,
    input  logic [1:0]             part,
    output bus_dec_t               dec
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);
    localparam logic [IDX_W-1:0] LOW_LAST = IDX_W'(LOW_WORDS - 1);
    localparam logic [SEL_W-1:0] MOD_SEL  = SEL_W'(NUM_OPS);

    logic [SEL_W-1:0] sel;
    logic [IDX_W-1:0] idx;
    logic             in_range;

    always_comb begin
        sel      = addr[IDX_W +: SEL_W];
        idx      = addr[IDX_W-1:0];
        in_range = (idx <= LAST_IDX);
        dec.is_op  = (sel < MOD_SEL);
        dec.is_mod = (sel == MOD_SEL);
        dec.op_id  = sel[OP_W-1:0];
        dec.idx    = idx;
        case (part_e'(part))
            PART_FULL: dec.in_win = in_range;
            PART_LOW:  dec.in_win = (idx <= LOW_LAST);
            PART_HIGH: dec.in_win = in_range && (idx > LOW_LAST);
            default:   dec.in_win = 1'b0;
        endcase
    end
endmodule

// File: rtl/opmem_bank.sv
module opmem_bank #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 48,
    parameter int IDX_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [WORD_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [WORD_W-1:0] rb_data
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

    logic [WORD_W-1:0] words_q [NUM_WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) words_q[i] <= '0;
        end else if (we && (widx <= LAST_IDX)) begin
            words_q[widx] <= wdata;
        end
    end

    always_comb begin
        ra_data = (ra_idx <= LAST_IDX) ? words_q[ra_idx] : '0;
        rb_data = (rb_idx <= LAST_IDX) ? words_q[rb_idx] : '0;
    end
endmodule

// File: rtl/operand_store.sv
module operand_store
    import opmem_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 48,
    parameter int LOW_WORDS = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SEL_W+IDX_W-1:0] bus_addr,
    input  logic                   bus_we,
    input  logic [WORD_W-1:0]      bus_wdata,
    output logic [WORD_W-1:0]      bus_rdata,
    input  logic [1:0]             part_sel,
    input  logic [OP_W-1:0]        dest_sel,
    input  logic [IDX_W-1:0]       dp_idx,
    input  logic                   dp_rd_en,
    input  logic [OP_W-1:0]        dp_x_sel,
    input  logic [OP_W-1:0]        dp_y_sel,
    input  logic                   dp_wr_en,
    input  logic [WORD_W-1:0]      dp_wdata,
    output logic [WORD_W-1:0]      dp_x_data,
    output logic [WORD_W-1:0]      dp_y_data,
    output logic [WORD_W-1:0]      dp_mod_data,
    output logic                   collision
);
    localparam int NBANK = NUM_OPS + 1;
    localparam int MOD_B = NUM_OPS;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
        logic [WORD_W-1:0] x;
        logic [WORD_W-1:0] y;
        logic [WORD_W-1:0] m;
        logic              coll;
    } regs_t;

    regs_t    regs_d, regs_q;
    bus_dec_t dec;
    logic     clash_op, clash_mod, clash, bus_wr_ok;

    logic [NBANK-1:0]  bank_we;
    logic [IDX_W-1:0]  bank_widx  [NBANK];
    logic [WORD_W-1:0] bank_wdata [NBANK];
    logic [WORD_W-1:0] bus_word   [NBANK];
    logic [WORD_W-1:0] dp_word    [NBANK];

    opmem_decode #(
        .NUM_WORDS (NUM_WORDS),
        .LOW_WORDS (LOW_WORDS)
    ) u_dec (
        .addr (bus_addr),
        .part (part_sel),
        .dec  (dec)
    );

    always_comb begin
        clash_op  = dec.is_op &&
                    ((dp_rd_en && ((dec.op_id == dp_x_sel) || (dec.op_id == dp_y_sel))) ||
                     (dp_wr_en && (dec.op_id == dest_sel)));
        clash_mod = dec.is_mod && dp_rd_en;
        clash     = bus_we && (clash_op || clash_mod);
        bus_wr_ok = bus_we && dec.in_win && (dec.is_op || dec.is_mod) && !clash;
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        if (g < NUM_OPS) begin : g_op
            logic dp_hit;
            assign dp_hit          = dp_wr_en && (dest_sel == OP_W'(g));
            assign bank_we[g]      = dp_hit || (bus_wr_ok && dec.is_op && (dec.op_id == OP_W'(g)));
            assign bank_widx[g]    = dp_hit ? dp_idx   : dec.idx;
            assign bank_wdata[g]   = dp_hit ? dp_wdata : bus_wdata;
        end else begin : g_mod
            assign bank_we[g]      = bus_wr_ok && dec.is_mod;
            assign bank_widx[g]    = dec.idx;
            assign bank_wdata[g]   = bus_wdata;
        end

        opmem_bank #(
            .WORD_W    (WORD_W),
            .NUM_WORDS (NUM_WORDS),
            .IDX_W     (IDX_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (bank_we[g]),
            .widx    (bank_widx[g]),
            .wdata   (bank_wdata[g]),
            .ra_idx  (dec.idx),
            .ra_data (bus_word[g]),
            .rb_idx  (dp_idx),
            .rb_data (dp_word[g])
        );
    end

    always_comb begin
        regs_d = regs_q;
        if (dec.in_win && dec.is_op)
            regs_d.rdata = bus_word[dest_sel];
        else if (dec.in_win && dec.is_mod)
            regs_d.rdata = bus_word[MOD_B];
        else
            regs_d.rdata = '0;
        regs_d.x    = dp_word[dp_x_sel];
        regs_d.y    = dp_word[dp_y_sel];
        regs_d.m    = dp_word[MOD_B];
        regs_d.coll = clash;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign bus_rdata   = regs_q.rdata;
    assign dp_x_data   = regs_q.x;
    assign dp_y_data   = regs_q.y;
    assign dp_mod_data = regs_q.m;
    assign collision   = regs_q.coll;
endmodule

// File: rtl/opmem_checker.sv
module opmem_checker
    import opmem_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 48,
    parameter int LOW_WORDS = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [SEL_W+IDX_W-1:0] bus_addr,
    input logic                   bus_we,
    input logic [WORD_W-1:0]      bus_wdata,
    input logic [WORD_W-1:0]      bus_rdata,
    input logic [1:0]             part_sel,
    input logic [OP_W-1:0]        dest_sel,
    input logic [IDX_W-1:0]       dp_idx,
    input logic                   dp_rd_en,
    input logic [OP_W-1:0]        dp_x_sel,
    input logic [OP_W-1:0]        dp_y_sel,
    input logic                   dp_wr_en,
    input logic [WORD_W-1:0]      dp_wdata,
    input logic [WORD_W-1:0]      dp_x_data,
    input logic [WORD_W-1:0]      dp_y_data,
    input logic [WORD_W-1:0]      dp_mod_data,
    input logic                   collision
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);
    localparam logic [IDX_W-1:0] LOW_LAST = IDX_W'(LOW_WORDS - 1);
    localparam logic [SEL_W-1:0] MOD_SEL  = SEL_W'(NUM_OPS);

    // R3
    unmapped_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[IDX_W +: SEL_W] > MOD_SEL) |=> (bus_rdata == '0));

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[IDX_W-1:0] > LAST_IDX) |=> (bus_rdata == '0));

    // R5
    low_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((part_sel == 2'b01) && (bus_addr[IDX_W-1:0] > LOW_LAST)) |=> (bus_rdata == '0));

    // R6
    dp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_idx > LAST_IDX) |=> ((dp_x_data == '0) && (dp_y_data == '0) && (dp_mod_data == '0)));

    // R8
    coll_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> !collision);

    // R8
    coll_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && dp_rd_en && (bus_addr[IDX_W +: SEL_W] == MOD_SEL)) |=> collision);
endmodule

bind operand_store opmem_checker #(
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS),
    .LOW_WORDS (LOW_WORDS)
) u_chk (.*);

// File: tb/operand_store_bench.sv
module operand_store_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  part = 2'b11;
    logic [1:0]  dest = '0;
    logic [5:0]  dpi = '0;
    logic        dp_rd = 1'b0;
    logic [1:0]  xs = '0;
    logic [1:0]  ys = '0;
    logic        dp_we = 1'b0;
    logic [31:0] dp_wd = '0;
    logic [31:0] xd, yd, md;
    logic        coll;

    int checks = 0;
    int fails  = 0;
    logic [31:0] mdl [0:4][0:47];

    always #2 clk = ~clk;

    operand_store u_operand_store (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .part_sel(part), .dest_sel(dest), .dp_idx(dpi),
        .dp_rd_en(dp_rd), .dp_x_sel(xs), .dp_y_sel(ys), .dp_wr_en(dp_we),
        .dp_wdata(dp_wd), .dp_x_data(xd), .dp_y_data(yd), .dp_mod_data(md),
        .collision(coll)
    );

    function automatic bit win_ok(logic [1:0] p, int w);
        case (p)
            2'b11:   return w < 48;
            2'b01:   return w < 16;
            2'b10:   return (w >= 16) && (w < 48);
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(string tag);
        int sel = int'(addr[8:6]);
        int w   = int'(addr[5:0]);
        int di  = int'(dpi);
        bit ok  = win_ok(part, w);
        bit clash = we && (((sel < 4) && ((dp_rd && (sel == int'(xs) || sel == int'(ys))) ||
                                         (dp_we && sel == int'(dest)))) ||
                           ((sel == 4) && dp_rd));
        logic [31:0] e_rd = '0;
        logic [31:0] e_x  = '0;
        logic [31:0] e_y  = '0;
        logic [31:0] e_m  = '0;
        string rtag;
        if (ok && sel < 4)  e_rd = mdl[dest][w];
        if (ok && sel == 4) e_rd = mdl[4][w];
        if (di < 48) begin
            e_x = mdl[xs][di];
            e_y = mdl[ys][di];
            e_m = mdl[4][di];
        end
        if (tag != "")     rtag = tag;
        else if (sel > 4)  rtag = "R3";
        else if (w > 47)   rtag = "R4";
        else if (!ok)      rtag = "R5";
        else               rtag = "R2";
        if (dp_we && di < 48) mdl[dest][di] = dp_wd;
        if (we && sel <= 4 && ok && !clash) mdl[sel][w] = wdata;
        @(posedge clk);
        @(negedge clk);
        check(rtag, rdata, e_rd);
        check("R6 x", xd, e_x);
        check("R6 y", yd, e_y);
        check("R6 m", md, e_m);
        check("R8", {31'd0, coll}, {31'd0, clash});
    endtask

    task automatic idle();
        we = 0; dp_rd = 0; dp_we = 0;
    endtask

    initial begin
        for (int o = 0; o < 5; o++)
            for (int i = 0; i < 48; i++) mdl[o][i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: outputs are zero right after reset
        check("R10 rdata", rdata, '0);
        check("R10 x", xd, '0);
        check("R10 coll", {31'd0, coll}, '0);
        addr = {3'd4, 6'd10};
        step("R10");

        // R1: write operand 2 word 7, read it back through dest_sel
        addr = {3'd2, 6'd7}; wdata = 32'hA5A5_0007; we = 1; step("R1");
        idle(); dest = 2; step("R1");
        addr = {3'd4, 6'd47}; wdata = 32'h0DD0_0047; we = 1; step("R1");
        idle(); step("R1");
        // R2: address selector does not pick the operand on reads
        addr = {3'd0, 6'd7}; dest = 2; step("R2");
        // R5: upper window drops word 3, lower window drops word 20
        part = 2'b10; addr = {3'd1, 6'd3}; wdata = 32'h1111_0003; we = 1; step("R5");
        idle(); part = 2'b11; dest = 1; step("R5");
        part = 2'b01; addr = {3'd1, 6'd20}; wdata = 32'h2222_0020; we = 1; step("R5");
        idle(); part = 2'b11; step("R5");
        // R4: word 50 ignored
        addr = {3'd1, 6'd50}; wdata = 32'h3333_0050; we = 1; step("R4");
        idle(); step("R4");
        // R9: write to operand 1 while the datapath reads it on x
        dp_rd = 1; xs = 1; ys = 0; dpi = 6'd9;
        addr = {3'd1, 6'd9}; wdata = 32'hDEAD_0009; we = 1; step("R9");
        idle(); dest = 1; step("R9");
        // R7: datapath write into operand 3, visible on the bus
        dp_we = 1; dest = 3; dpi = 6'd20; dp_wd = 32'hC0DE_0020; step("R7");
        idle(); addr = {3'd0, 6'd20}; step("R7");
        // R9: datapath write wins over a clashing bus write
        dp_we = 1; dest = 0; dpi = 6'd5; dp_wd = 32'h0BAD_0005;
        addr = {3'd0, 6'd5}; wdata = 32'hFFFF_0005; we = 1; step("R9");
        idle(); step("R9");

        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom_range(0, 9));
            logic [2:0] s = (r < 8) ? 3'($urandom_range(0, 4)) : 3'($urandom_range(5, 7));
            logic [5:0] ix = ($urandom_range(0, 9) < 9) ? 6'($urandom_range(0, 47))
                                                       : 6'($urandom_range(48, 63));
            addr  = {s, ix};
            we    = ($urandom_range(0, 1) == 1);
            wdata = $urandom;
            part  = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 2)) : 2'b11;
            dest  = 2'($urandom_range(0, 3));
            dpi   = ($urandom_range(0, 15) == 0) ? 6'($urandom_range(48, 63))
                                                 : 6'($urandom_range(0, 47));
            dp_rd = ($urandom_range(0, 3) == 0);
            xs    = 2'($urandom_range(0, 3));
            ys    = 2'($urandom_range(0, 3));
            dp_we = ($urandom_range(0, 6) == 0);
            dp_wd = $urandom;
            step("");
        end
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule